// File: doc/BRIEF.md
# Overcurrent Alert and Status Logic

This block decides when an active-high alert output is raised for a supply rail and keeps a six-bit status word that firmware can poll. It combines three fault sources, each enabled on its own and each held in its own latch. The first is a digitised overcurrent comparator. Its level is glitch-filtered and then qualified by a cycle counter that takes the place of an external delay capacitor. The second compares each current-conversion result from the ADC against an 8-bit threshold. The third is a software request that forces the alert.

The enable bits and the threshold come from configuration registers held elsewhere. A one-cycle clear request models the self-clearing clear bit in those registers. An active-low clear pin gives a hardware path that drops a latched comparator fault.

Status word layout, bit 0 first: last conversion over threshold (live), ADC alert (latched), filtered comparator level (live), comparator alert (latched), software-off request (live), software-off alert (latched).

Top module: `ocp_alert`

## Requirements
- R1: After reset, alert is 0 and all six status bits are 0.
- R2: With enable bit 0 set, a conversion strobe whose code bits [11:4] are strictly greater than the threshold sets status bit 1 and alert on the clock edge that samples the strobe. A code whose top byte equals the threshold does not set it.
- R3: With only enable bit 1 set, status bit 1 is set on the RUN_LEN-th (default 4) consecutive over-threshold conversion. A conversion that is not over threshold restarts the count.
- R4: Status bit 0 holds the over-threshold result of the most recent conversion, whatever the enables are.
- R5: A comparator input high for fewer than GLITCH_CYC consecutive cycles changes neither status bit 2 nor any latch. Status bit 2 rises on the GLITCH_CYC-th consecutive high sample.
- R6: With enable bit 2 set, status bit 3 latches TRIP_CYC+1 edges after status bit 2 rises, provided status bit 2 stays high. If the filtered level drops before that point, the delay counter restarts from zero.
- R7: A source whose enable bit is clear never sets its latch, while the live bits 0 and 2 still report.
- R8: Status bit 4 follows the software-off input. With enable bit 3 set, that input also latches status bit 5.
- R9: A clear-request pulse clears status bits 1, 3 and 5 on the next edge. A latch whose enabled cause is still present stays set.
- R10: Holding the clear pin low clears status bit 3 only, unless its enabled cause is still present.
- R11: The alert output is high exactly when at least one of status bits 1, 3 and 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_in | input | 1 | Raw overcurrent comparator level |
| conv_valid | input | 1 | One-cycle strobe for a new current result |
| conv_code | input | 12 | Current conversion result |
| trip_level | input | 8 | ADC alert threshold, compared against code bits [11:4] |
| alert_en | input | 4 | Enables: [0] single-conversion ADC, [1] consecutive ADC, [2] comparator, [3] software-off |
| clr_req | input | 1 | One-cycle clear of status bits 1, 3, 5 |
| swoff | input | 1 | Software-off request |
| clr_n | input | 1 | Clear pin, active low, clears comparator latch |
| alert | output | 1 | Combined alert, active high |
| status | output | 6 | Status word, layout as described above |

## Verification
The ADC path is driven with random 12-bit codes against random thresholds, under single mode and under consecutive mode. This shows whether the comparison uses the right bits and whether the run counter restarts on a single low result. Directed comparator pulses one cycle short of the filter length, a fault dropped one cycle before terminal count, and a fault held through it separate filter, timer-restart and latch-timing faults. Clear requests arrive while the cause persists and again after it has gone, which checks that setting wins over clearing. A clear-pin pulse is applied while the ADC latch is held, which checks that the pin reaches only the comparator latch.

// File: rtl/ocp_alert.sv
module ocp_alert #(
  parameter int GLITCH_CYC = 4,
  parameter int TRIP_CYC   = 16,
  parameter int RUN_LEN    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_in,
  input  logic        conv_valid,
  input  logic [11:0] conv_code,
  input  logic [7:0]  trip_level,
  input  logic [3:0]  alert_en,
  input  logic        clr_req,
  input  logic        swoff,
  input  logic        clr_n,
  output logic        alert,
  output logic [5:0]  status
);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int TW = $clog2(TRIP_CYC + 1);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic          filt;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tcnt;
  logic [RW-1:0] run;
  logic          adc_hit, adc_alert, oc_alert, off_alert;

  wire           over    = conv_code[11:4] > trip_level;
  wire [RW-1:0]  run_nx  = !over ? '0 : (run == RW'(RUN_LEN) ? run : run + 1'b1);
  wire           tmr_end = filt && (tcnt == TW'(TRIP_CYC));
  wire           adc_set = conv_valid && over &&
                           (alert_en[0] || (alert_en[1] && run_nx == RW'(RUN_LEN)));
  wire           oc_set  = alert_en[2] && tmr_end;
  wire           off_set = alert_en[3] && swoff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 1'b0;
      gcnt <= '0;
    end else if (cmp_in == filt) begin
      gcnt <= '0;
    end else if (gcnt == GW'(GLITCH_CYC - 1)) begin
      filt <= cmp_in;
      gcnt <= '0;
    end else begin
      gcnt <= gcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tcnt <= '0;
    else if (!filt)           tcnt <= '0;
    else if (!tmr_end)        tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      adc_hit <= 1'b0;
    end else if (conv_valid) begin
      run     <= run_nx;
      adc_hit <= over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_alert <= 1'b0;
      oc_alert  <= 1'b0;
      off_alert <= 1'b0;
    end else begin
      adc_alert <= adc_set || (adc_alert && !clr_req);
      oc_alert  <= oc_set  || (oc_alert && !clr_req && clr_n);
      off_alert <= off_set || (off_alert && !clr_req);
    end
  end

  assign status = {off_alert, swoff, oc_alert, filt, adc_alert, adc_hit};
  assign alert  = adc_alert | oc_alert | off_alert;

  assert_adc_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_alert) |-> $past(conv_valid && over && (alert_en[0] || alert_en[1])));

  assert_filter_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt) |-> $past(cmp_in));

  assert_timer_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_alert) |-> $past(filt && tcnt == TW'(TRIP_CYC) && alert_en[2]));

  assert_off_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_alert) |-> $past(swoff && alert_en[3]));

  assert_clear_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !adc_set) |=> !adc_alert);

  assert_clear_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !oc_set) |=> !oc_alert);
endmodule

// File: tb/ocp_alert_test.sv
module ocp_alert_test;
  localparam int G = 4;
  localparam int T = 16;
  localparam int RL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_in = 1'b0, conv_valid = 1'b0, clr_req = 1'b0, swoff = 1'b0, clr_n = 1'b1;
  logic [11:0] conv_code = '0;
  logic [7:0]  trip_level = 8'hFF;
  logic [3:0]  alert_en = '0;
  logic        alert;
  logic [5:0]  status;

  int total = 0, bad = 0;
  bit done = 0;

  ocp_alert #(.GLITCH_CYC(G), .TRIP_CYC(T), .RUN_LEN(RL)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .conv_valid(conv_valid),
    .conv_code(conv_code), .trip_level(trip_level), .alert_en(alert_en),
    .clr_req(clr_req), .swoff(swoff), .clr_n(clr_n), .alert(alert), .status(status));

  always #4 clk = ~clk;

  function automatic bit over_f(input logic [11:0] c, input logic [7:0] th);
    return c[11:4] > th;
  endfunction

  function automatic int run_f(input int r, input bit o);
    return !o ? 0 : (r == RL ? r : r + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic conv(input logic [11:0] c);
    conv_valid = 1'b1; conv_code = c;
    step(1);
    conv_valid = 1'b0;
  endtask

  task automatic clear;
    clr_req = 1'b1; step(1); clr_req = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int run_m;
    bit adc_m;
    void'($urandom(32'd1234));
    step(2);
    chk("R1 status", status, 0);
    chk("R1 alert", alert, 0);
    rst_n = 1'b1;
    step(1);

    // directed R2: equal does not trip, greater trips
    alert_en = 4'b0001; trip_level = 8'h40;
    conv(12'h40F);
    chk("R2 equal top byte", status[1], 0);
    chk("R4 equal not over", status[0], 0);
    conv(12'h410);
    chk("R2 over trips", status[1], 1);
    chk("R11 alert from adc", alert, 1);
    conv(12'h000);
    chk("R4 follows latest", status[0], 0);
    chk("R2 latch held", status[1], 1);
    clear;
    chk("R9 clear adc", status[1], 0);
    chk("R11 alert low", alert, 0);

    // directed R3: consecutive mode
    alert_en = 4'b0010; trip_level = 8'h80;
    for (int i = 0; i < RL - 1; i++) conv(12'hFFF);
    chk("R3 short run", status[1], 0);
    conv(12'h100);
    for (int i = 0; i < RL - 1; i++) conv(12'hFFF);
    chk("R3 run restarted", status[1], 0);
    conv(12'hFFF);
    chk("R3 full run trips", status[1], 1);
    clear;
    chk("R9 clear again", status[1], 0);

    // random ADC phase
    adc_m = 0; run_m = 0;
    conv(12'h000);
    for (int i = 0; i < 400; i++) begin
      logic [11:0] c;
      bit o;
      if (i % 50 == 0) begin
        trip_level = 8'($urandom_range(0, 255));
        alert_en = ($urandom_range(0, 1) != 0) ? 4'b0001 : 4'b0010;
      end
      if ($urandom_range(0, 9) == 0) begin
        clear; adc_m = 0;
      end else begin
        c = 12'($urandom_range(0, 4095));
        if ($urandom_range(0, 2) == 0) c[11:4] = trip_level + 8'd1;
        o = over_f(c, trip_level);
        run_m = run_f(run_m, o);
        if (o && (alert_en[0] || (alert_en[1] && run_m == RL))) adc_m = 1;
        conv(c);
        chk("R4 random hit", status[0], o);
      end
      chk("R2 R3 random latch", status[1], adc_m);
      chk("R11 random alert", alert, adc_m);
    end
    clear;
    trip_level = 8'hFF;

    // R5 glitch filter
    alert_en = 4'b0100;
    cmp_in = 1'b1; step(G - 1); cmp_in = 1'b0;
    step(T + G + 4);
    chk("R5 glitch ignored", status[2], 0);
    chk("R5 no latch", status[3], 0);

    // R6 timer restart
    cmp_in = 1'b1; step(T - 1); cmp_in = 1'b0;
    step(G + 2);
    chk("R6 dropped before end", status[3], 0);
    cmp_in = 1'b1; step(G);
    chk("R5 filtered level up", status[2], 1);
    step(T);
    chk("R6 not before terminal", status[3], 0);
    step(1);
    chk("R6 latched at terminal", status[3], 1);
    chk("R11 alert from comparator", alert, 1);
    clear;
    chk("R9 re-set while cause persists", status[3], 1);
    cmp_in = 1'b0; step(G);
    chk("R6 live level drops", status[2], 0);
    chk("R6 latch held", status[3], 1);

    // R10 clear pin only hits comparator latch
    alert_en = 4'b0101; trip_level = 8'h10;
    conv(12'hFFF);
    clr_n = 1'b0; step(1); clr_n = 1'b1;
    chk("R10 pin clears comparator", status[3], 0);
    chk("R10 pin leaves adc", status[1], 1);
    clear;
    trip_level = 8'hFF;

    // R7 disabled sources
    alert_en = 4'b0000; trip_level = 8'h00;
    conv(12'hFFF);
    cmp_in = 1'b1; step(G + T + 4);
    chk("R7 live adc bit", status[0], 1);
    chk("R7 live cmp bit", status[2], 1);
    chk("R7 no latches", {status[5], status[3], status[1]}, 0);
    chk("R7 alert low", alert, 0);
    cmp_in = 1'b0; step(G + 1);
    trip_level = 8'hFF; conv(12'h000);

    // R8 software off
    swoff = 1'b1; step(1);
    chk("R8 off status only", status, 6'b010000);
    chk("R8 disabled no alert", alert, 0);
    alert_en = 4'b1000; step(1);
    chk("R8 off alert latched", status[5], 1);
    chk("R11 alert from off", alert, 1);
    clear;
    chk("R9 off re-sets", status[5], 1);
    swoff = 1'b0; step(1);
    chk("R8 latch holds", status[5], 1);
    clear;
    chk("R9 off cleared", status[5], 0);
    chk("R1 R11 all quiet", {alert, status}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule